// File: doc/BRIEF.md
# Ring Descriptor Queue Manager

This block keeps the pointers and counts for a circular queue of command descriptors that a DMA or XOR engine works through. Software hands over work by writing how many new descriptors it placed in the ring, not where they are. The block offers them to the engine one at a time through a fetch request/acknowledge pair and presents the ring index of each one as it is taken. The engine reports completions in the order it fetched. Finished entries stay counted as completed but unreleased until software writes a release count, which also moves the oldest-completed index forward.

The software side is a single-cycle register port: a write strobe with address and data, and a read data bus driven combinationally from the address. Configuration sets the ring size and the descriptor format. Each format caps how many entries the ring may have. A halt bit stops new fetches without losing any count. Requests that would overfill the ring, or release more than has completed, are trimmed to what is legal and leave a sticky error flag.

Top module: `ring_queue_mgr`

## Requirements
- R1: After reset the unit is halted, the format code reads 7, the ring size reads 16, the done status and error flags read zero, and no fetch is requested.
- R2: Register 0 holds the format code. Writing 1 selects the small format, with a cap of 16384 entries. Writing 7 selects the large format, with a cap of 4096 entries. Any other value is ignored. A write is accepted only while the ring holds no entries, and an accepted write lowers the size to the new cap if the size is larger.
- R3: Register 1 holds the ring size. The written value is clamped into the range 1 to the cap of the current format. The write is taken only while posted, in-flight and completed counts are all zero. Every accepted configuration write returns all ring indices to 0.
- R4: Writing N to register 2 posts N descriptors, clipped to the free room (size minus posted, in-flight and completed). A clipped write sets overflow flag bit 0 of register 6.
- R5: fetch_req is high exactly when the unit is not halted and the posted count is nonzero. While fetch_req and fetch_ack are both high, fetch_idx shows the descriptor taken, and the fetch index then advances by one, wrapping to 0 at the ring size.
- R6: A cycle with cmpl_valid and a nonzero in-flight count moves one descriptor to completed, including while halted. cmpl_valid with nothing in flight is ignored.
- R7: Register 5 reads the completed-unreleased count in bits [14:0] and the oldest completed index in bits [29:16]. All other bits read zero.
- R8: Writing N to register 3 releases min(N, completed) entries and advances the oldest index by that amount, with wrap. N above the completed count sets underflow flag bit 1 of register 6.
- R9: Register 4 bit 0 is the halt bit: 1 halts and 0 enables. It reads back in bit 0.
- R10: The error flags stay set until software writes 1 to the matching bit of register 6. Writing 0 leaves a flag unchanged.
- R11: Reads of registers 2, 3 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, used for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| fetch_req | output | 1 | A posted descriptor is available to the engine |
| fetch_ack | input | 1 | Engine takes the offered descriptor this cycle |
| fetch_idx | output | 14 | Ring index of the offered descriptor |
| cmpl_valid | input | 1 | Engine finished the oldest in-flight descriptor |

## Verification
A wrong posted count shows on fetch_req within the same cycle. A fetch pointer that wraps at the wrong size gives a wrong fetch_idx on the next acknowledged fetch. Errors in the completed count or the release pointer appear in the done word at the next read of register 5. A wrong free-room calculation may not show until the ring fills, so the random stimulus runs a seven-entry ring and keeps it near full, where a clipping error sets the overflow flag at the wrong time.

// File: rtl/rqm_pkg.sv
package rqm_pkg;

  typedef enum logic [2:0] {
    RA_MODE = 3'd0,
    RA_SIZE = 3'd1,
    RA_ADD  = 3'd2,
    RA_REL  = 3'd3,
    RA_HALT = 3'd4,
    RA_DONE = 3'd5,
    RA_ERR  = 3'd6
  } reg_addr_e;

  localparam logic [31:0] MODE_SMALL = 32'd1;
  localparam logic [31:0] MODE_LARGE = 32'd7;

  function automatic logic [31:0] f_min(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  // Advance a ring index by n (n <= size), wrapping at size.
  function automatic logic [31:0] f_wrap_add(input logic [31:0] ptr, input logic [31:0] n,
                                             input logic [31:0] size);
    logic [31:0] s;
    s = ptr + n;
    return (s >= size) ? (s - size) : s;
  endfunction

  function automatic logic [31:0] f_ring_cap(input logic [31:0] mode, input int small_log2,
                                             input int large_log2);
    return (mode == MODE_SMALL) ? (32'd1 << small_log2) : (32'd1 << large_log2);
  endfunction

  function automatic logic [31:0] f_size_clamp(input logic [31:0] val, input logic [31:0] cap);
    return (val == 32'd0) ? 32'd1 : f_min(val, cap);
  endfunction

endpackage

// File: rtl/rqm_cfg.sv
module rqm_cfg
  import rqm_pkg::*;
#(
  parameter int IDX_W      = 14,
  parameter int LARGE_LOG2 = 12,
  parameter int RESET_SIZE = 16,
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic             wr_size,
  input  logic             wr_halt,
  input  logic [31:0]      wdata,
  input  logic             ring_empty,
  output logic [2:0]       mode_q,
  output logic [CNT_W-1:0] size_q,
  output logic             halt_q,
  output logic             cfg_reload
);

  logic        mode_ok;
  logic        size_ok;
  logic [31:0] cap_now;
  logic [31:0] cap_new;
  logic [31:0] size_next;

  assign cap_now   = f_ring_cap(32'(mode_q), IDX_W, LARGE_LOG2);
  assign cap_new   = f_ring_cap(wdata, IDX_W, LARGE_LOG2);
  assign mode_ok   = wr_mode && ring_empty && (wdata == MODE_SMALL || wdata == MODE_LARGE);
  assign size_ok   = wr_size && ring_empty;
  assign size_next = mode_ok ? f_min(32'(size_q), cap_new) : f_size_clamp(wdata, cap_now);
  assign cfg_reload = mode_ok || size_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_LARGE[2:0];
      size_q <= CNT_W'(RESET_SIZE);
      halt_q <= 1'b1;
    end else begin
      if (mode_ok)    mode_q <= wdata[2:0];
      if (cfg_reload) size_q <= size_next[CNT_W-1:0];
      if (wr_halt)    halt_q <= wdata[0];
    end
  end

  // R3: the size always sits between 1 and the cap of the current format
  a_r3_size_in_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q != '0) && (32'(size_q) <= cap_now));

  // R2: a format write while entries are outstanding leaves the format unchanged
  a_r2_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !ring_empty) |=> $stable(mode_q));

endmodule

// File: rtl/rqm_track.sv
module rqm_track
  import rqm_pkg::*;
#(
  parameter int IDX_W = 14,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] size_q,
  input  logic             halt_q,
  input  logic             cfg_reload,
  input  logic             add_wr,
  input  logic             rel_wr,
  input  logic             err_wr,
  input  logic [31:0]      wdata,
  input  logic             fetch_ack,
  input  logic             cmpl_valid,
  output logic             fetch_req,
  output logic [IDX_W-1:0] fetch_idx,
  output logic [CNT_W-1:0] done_cnt,
  output logic [IDX_W-1:0] rel_ptr,
  output logic             ovf_q,
  output logic             udf_q,
  output logic             ring_empty
);

  logic [CNT_W-1:0] pend_q, fly_q, done_q;
  logic [IDX_W-1:0] fptr_q, rptr_q;

  logic [31:0] size32, occ32, room32;
  logic [31:0] add_acc, rel_acc;
  logic        add_ovf, rel_udf;
  logic        fetch_fire, cmpl_fire;
  logic [31:0] pend_n, fly_n, done_n;
  logic [31:0] fptr_adv, rptr_adv;

  assign size32  = 32'(size_q);
  assign occ32   = 32'(pend_q) + 32'(fly_q) + 32'(done_q);
  assign room32  = size32 - occ32;

  assign add_acc = add_wr ? f_min(wdata, room32) : 32'd0;
  assign add_ovf = add_wr && (wdata > room32);
  assign rel_acc = rel_wr ? f_min(wdata, 32'(done_q)) : 32'd0;
  assign rel_udf = rel_wr && (wdata > 32'(done_q));

  assign fetch_req  = !halt_q && (pend_q != '0);
  assign fetch_fire = fetch_req && fetch_ack;
  assign cmpl_fire  = cmpl_valid && (fly_q != '0);

  assign pend_n = 32'(pend_q) + add_acc - 32'(fetch_fire);
  assign fly_n  = 32'(fly_q) + 32'(fetch_fire) - 32'(cmpl_fire);
  assign done_n = 32'(done_q) + 32'(cmpl_fire) - rel_acc;

  assign fptr_adv = f_wrap_add(32'(fptr_q), 32'(fetch_fire), size32);
  assign rptr_adv = f_wrap_add(32'(rptr_q), rel_acc, size32);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      fly_q  <= '0;
      done_q <= '0;
      fptr_q <= '0;
      rptr_q <= '0;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      pend_q <= pend_n[CNT_W-1:0];
      fly_q  <= fly_n[CNT_W-1:0];
      done_q <= done_n[CNT_W-1:0];
      if (cfg_reload) begin
        fptr_q <= '0;
        rptr_q <= '0;
      end else begin
        fptr_q <= fptr_adv[IDX_W-1:0];
        rptr_q <= rptr_adv[IDX_W-1:0];
      end
      ovf_q <= (ovf_q && !(err_wr && wdata[0])) || add_ovf;
      udf_q <= (udf_q && !(err_wr && wdata[1])) || rel_udf;
    end
  end

  assign fetch_idx  = fptr_q;
  assign done_cnt   = done_q;
  assign rel_ptr    = rptr_q;
  assign ring_empty = (occ32 == 32'd0);

  // R4: outstanding entries never exceed the ring size
  a_r4_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ32 <= size32);

  // R5: the offered index is always inside the ring
  a_r5_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fetch_idx) < size32);

  // R6: an accepted completion with no release raises the done count by one
  a_r6_cmpl_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_fire && !rel_wr) |=> (32'(done_cnt) == 32'($past(done_cnt)) + 32'd1));

  // R10: flags hold until cleared
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(err_wr && wdata[0])) |=> ovf_q);
  a_r10_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_q && !(err_wr && wdata[1])) |=> udf_q);

endmodule

// File: rtl/ring_queue_mgr.sv
module ring_queue_mgr
  import rqm_pkg::*;
#(
  parameter int IDX_W      = 14,
  parameter int LARGE_LOG2 = 12,
  parameter int RESET_SIZE = 16,
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             fetch_req,
  input  logic             fetch_ack,
  output logic [IDX_W-1:0] fetch_idx,
  input  logic             cmpl_valid
);

  logic             wr_mode, wr_size, wr_add, wr_rel, wr_halt, wr_err;
  logic [2:0]       mode_q;
  logic [CNT_W-1:0] size_q;
  logic             halt_q, cfg_reload, ring_empty;
  logic [CNT_W-1:0] done_cnt;
  logic [IDX_W-1:0] rel_ptr;
  logic             ovf_q, udf_q;

  assign wr_mode = reg_wr && (reg_addr == RA_MODE);
  assign wr_size = reg_wr && (reg_addr == RA_SIZE);
  assign wr_add  = reg_wr && (reg_addr == RA_ADD);
  assign wr_rel  = reg_wr && (reg_addr == RA_REL);
  assign wr_halt = reg_wr && (reg_addr == RA_HALT);
  assign wr_err  = reg_wr && (reg_addr == RA_ERR);

  rqm_cfg #(
    .IDX_W(IDX_W), .LARGE_LOG2(LARGE_LOG2), .RESET_SIZE(RESET_SIZE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_mode(wr_mode), .wr_size(wr_size), .wr_halt(wr_halt),
    .wdata(reg_wdata), .ring_empty(ring_empty),
    .mode_q(mode_q), .size_q(size_q), .halt_q(halt_q), .cfg_reload(cfg_reload)
  );

  rqm_track #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .size_q(size_q), .halt_q(halt_q), .cfg_reload(cfg_reload),
    .add_wr(wr_add), .rel_wr(wr_rel), .err_wr(wr_err), .wdata(reg_wdata),
    .fetch_ack(fetch_ack), .cmpl_valid(cmpl_valid),
    .fetch_req(fetch_req), .fetch_idx(fetch_idx),
    .done_cnt(done_cnt), .rel_ptr(rel_ptr),
    .ovf_q(ovf_q), .udf_q(udf_q), .ring_empty(ring_empty)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_MODE: reg_rdata = 32'(mode_q);
      RA_SIZE: reg_rdata = 32'(size_q);
      RA_HALT: reg_rdata = {31'd0, halt_q};
      RA_DONE: begin
        reg_rdata[CNT_W-1:0]   = done_cnt;
        reg_rdata[16 +: IDX_W] = rel_ptr;
      end
      RA_ERR:  reg_rdata = {30'd0, udf_q, ovf_q};
      default: reg_rdata = '0;
    endcase
  end

  // R9: a halted unit never offers a descriptor
  a_r9_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !fetch_req);

  // R5: an acknowledged fetch moves the offered index on the next cycle
  a_r5_fetch_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && !cfg_reload && size_q != CNT_W'(1)) |=> !$stable(fetch_idx));

endmodule

// File: tb/ring_queue_mgr_bench.sv
`timescale 1ns/1ps
module ring_queue_mgr_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        fetch_req;
  logic        fetch_ack = 1'b0;
  logic [13:0] fetch_idx;
  logic        cmpl_valid = 1'b0;

  ring_queue_mgr u_ring_queue_mgr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
    .fetch_ack(fetch_ack), .fetch_idx(fetch_idx), .cmpl_valid(cmpl_valid)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  int m_mode = 7, m_size = 16, m_halt = 1;
  int m_pend = 0, m_fly = 0, m_done = 0, m_fptr = 0, m_rptr = 0;
  int m_ovf = 0, m_udf = 0;

  function automatic int cap_of(int mode);
    return (mode == 1) ? 16384 : 4096;
  endfunction

  function automatic int step_ring(int p, int n, int sz);
    int t;
    t = p + n;
    if (t >= sz) t = t - sz;
    return t;
  endfunction

  function automatic logic [31:0] exp_reg(int a);
    case (a)
      0: return 32'(m_mode);
      1: return 32'(m_size);
      4: return 32'(m_halt);
      5: return (32'(m_rptr) << 16) | 32'(m_done);
      6: return 32'((m_udf << 1) | m_ovf);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic rd(input int a, input string tag);
    reg_wr = 1'b0;
    reg_addr = 3'(a);
    #1;
    chk(tag, reg_rdata, exp_reg(a));
  endtask

  task automatic cyc(input bit wr, input int a, input logic [31:0] d, input bit ack, input bit cm);
    int occ, room, fa, ca, add, rel, novf, nudf, ereq;
    reg_wr = wr; reg_addr = 3'(a); reg_wdata = d; fetch_ack = ack; cmpl_valid = cm;
    #1;
    ereq = (m_halt == 0 && m_pend > 0) ? 1 : 0;
    chk("R5 fetch_req", 32'(fetch_req), 32'(ereq));
    if (ereq == 1 && ack) chk("R5 fetch_idx", 32'(fetch_idx), 32'(m_fptr));
    occ = m_pend + m_fly + m_done;
    room = m_size - occ;
    fa = (ack && ereq == 1) ? 1 : 0;
    ca = (cm && m_fly > 0) ? 1 : 0;
    add = 0; rel = 0; novf = 0; nudf = 0;
    if (wr) begin
      case (a)
        0: if (occ == 0 && (d == 32'd1 || d == 32'd7)) begin
             m_mode = int'(d);
             if (m_size > cap_of(m_mode)) m_size = cap_of(m_mode);
             m_fptr = 0; m_rptr = 0;
           end
        1: if (occ == 0) begin
             if (d == 32'd0) m_size = 1;
             else if (d > 32'(cap_of(m_mode))) m_size = cap_of(m_mode);
             else m_size = int'(d);
             m_fptr = 0; m_rptr = 0;
           end
        2: begin
             if (d > 32'(room)) begin add = room; novf = 1; end
             else add = int'(d);
           end
        3: begin
             if (d > 32'(m_done)) begin rel = m_done; nudf = 1; end
             else rel = int'(d);
           end
        4: m_halt = int'(d[0]);
        6: begin
             if (d[0]) m_ovf = 0;
             if (d[1]) m_udf = 0;
           end
        default: ;
      endcase
    end
    m_pend = m_pend + add - fa;
    m_fly  = m_fly + fa - ca;
    m_done = m_done + ca - rel;
    m_fptr = step_ring(m_fptr, fa, m_size);
    m_rptr = step_ring(m_rptr, rel, m_size);
    if (novf) m_ovf = 1;
    if (nudf) m_udf = 1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; fetch_ack = 1'b0; cmpl_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk("R1 fetch_req after reset", 32'(fetch_req), 32'd0);
    rd(0, "R1 mode"); rd(1, "R1 size"); rd(4, "R1 halt"); rd(5, "R1 done"); rd(6, "R1 err");
    // R11 write-only and unused reads
    rd(2, "R11 add reads 0"); rd(3, "R11 release reads 0"); rd(7, "R11 unused reads 0");
    // R2 / R3 configuration
    cyc(1, 0, 32'd3, 0, 0);      rd(0, "R2 bad code ignored");
    cyc(1, 0, 32'd1, 0, 0);      rd(0, "R2 small format"); rd(1, "R2 size kept");
    cyc(1, 1, 32'd20000, 0, 0);  rd(1, "R3 clamp to 16384");
    cyc(1, 0, 32'd7, 0, 0);      rd(1, "R2 size lowered to 4096");
    cyc(1, 1, 32'd0, 0, 0);      rd(1, "R3 zero becomes 1");
    cyc(1, 1, 32'd5, 0, 0);      rd(1, "R3 size 5");
    // R9 enable, R4 add, R5 fetch
    cyc(1, 4, 32'd0, 0, 0);      rd(4, "R9 enabled");
    cyc(1, 2, 32'd3, 0, 0);
    cyc(1, 4, 32'd1, 1, 0);      rd(4, "R9 halted");
    cyc(0, 0, 32'd0, 1, 0);      // R9: halted, no fetch while posted
    cyc(1, 4, 32'd0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 32'd0, 1, 0);
    // R6 completions while halted
    cyc(1, 4, 32'd1, 0, 1);
    cyc(0, 0, 32'd0, 0, 1);      rd(5, "R6 R7 two done");
    cyc(0, 0, 32'd0, 0, 1);
    cyc(0, 0, 32'd0, 0, 1);      rd(5, "R6 extra completion ignored");
    // R3 size change refused when not empty
    cyc(1, 1, 32'd9, 0, 0);      rd(1, "R3 size locked");
    // R8 release and underflow
    cyc(1, 3, 32'd2, 0, 0);      rd(5, "R8 release 2");
    cyc(1, 3, 32'd5, 0, 0);      rd(5, "R8 clipped release"); rd(6, "R8 underflow flag");
    // R4 overflow, R10 clear
    cyc(1, 2, 32'd9, 0, 0);      rd(6, "R4 overflow flag");
    cyc(1, 6, 32'd2, 0, 0);      rd(6, "R10 clear underflow only");
    cyc(1, 6, 32'd0, 0, 0);      rd(6, "R10 zero write keeps flag");
    // R5 wrap of fetch index, R8 wrap of release index
    cyc(1, 4, 32'd0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 32'd0, 1, 1);
    cyc(0, 0, 32'd0, 0, 1);
    cyc(1, 3, 32'd5, 0, 0);      rd(5, "R8 wrapped release index");
    cyc(1, 6, 32'd3, 0, 0);
    cyc(1, 1, 32'd7, 0, 0);      rd(1, "R3 size 7 for random run");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int p;
      bit ack, cm;
      p = int'($urandom % 16);
      ack = ($urandom % 3) != 0;
      cm = ($urandom % 2) == 1;
      if (p < 4)       cyc(1, 2, (($urandom % 8) == 0) ? 32'd9 : 32'($urandom % 5), ack, cm);
      else if (p < 6)  cyc(1, 3, 32'($urandom % 4), ack, cm);
      else if (p == 6) cyc(1, 4, 32'(($urandom % 4) == 0), ack, cm);
      else if (p == 7) cyc(1, 6, 32'($urandom % 4), ack, cm);
      else             cyc(0, 0, 32'd0, ack, cm);
      if ((i % 8) == 0) begin
        rd(5, "R7 done word random");
        rd(6, "R10 flags random");
        rd(4, "R9 halt random");
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule